// File: doc/BRIEF.md
# Byte-Lane Steering Memory Slave

This block is a zero-wait-state memory target for a pipelined address/data bus with a 64-bit read bus and a 64-bit write bus. It holds a small array of doublewords, each split into eight byte lanes. During the address phase it samples the transfer attributes: type, direction, byte address and size. It uses the low three address bits and the size to work out which lanes carry data. In the following data phase it writes only those lanes from the write bus, or returns only those lanes on the read bus.

Lanes follow a fixed little-endian map. Byte offset k within a doubleword sits on data bits 8k+7 down to 8k, for both buses. Single-beat transfers of 1, 2, 3, 4 or 8 bytes are accepted. A transfer that would run past the end of its doubleword, or that carries an unsupported size code, completes as a harmless no-op. Every response is OKAY, with no wait state.

A small state machine tracks the data phase. Its states are PH_NONE (no data phase), PH_WRITE (lanes are being written), PH_READ (lanes are being returned) and PH_DROP (an accepted but unservable transfer). The transitions are as follows:
- Any state goes to PH_WRITE or PH_READ when `hready` is high and a valid NONSEQ/SEQ transfer is presented. The choice between them follows `hwrite`.
- Any state goes to PH_DROP when `hready` is high and the presented transfer is NONSEQ/SEQ but has a bad size or crosses the doubleword boundary.
- Any state goes to PH_NONE when `hready` is high with an IDLE or BUSY type.
- Every state holds when `hready` is low.

Top module: `ahb_lane_mem`

## Requirements
- R1: `hreadyout` is always 1 and `hresp` is always 0 (OKAY), so every transfer completes with zero wait states.
- R2: Transfer types IDLE (2'b00) and BUSY (2'b01) request nothing. In the following cycle `hrdata` is zero, and memory is not modified even if `hwrite` is high.
- R3: Types NONSEQ (2'b10) and SEQ (2'b11) sampled with `hready` high open a data phase in the next cycle. A write stores `hwdata` at the end of that cycle. A read drives `hrdata` combinationally during it.
- R4: While `hready` is low, address-phase signals are not sampled and the data-phase state holds, so a transfer presented then has no effect.
- R5: Byte offset k (address bits [2:0]) maps to data bits [8k+7:8k] on both `hwdata` and `hrdata`. Address bits [IDX_W+2:3] select the doubleword.
- R6: `hsize` holds the byte count minus one. The supported codes are 0 (1 byte), 1 (2 bytes), 2 (3 bytes), 3 (4 bytes) and 7 (8 bytes). A transfer occupies lanes offset through offset+count-1.
- R7: A transfer with offset+count greater than 8, or with `hsize` 4, 5 or 6, is a no-op. It writes nothing, returns zero data and is answered OKAY.
- R8: On a read, lanes outside the transfer are driven as zero.
- R9: A write modifies only the lanes of the transfer. Other lanes of the doubleword keep their contents whatever `hwdata` carries on them.
- R10: After reset the data-phase state is PH_NONE and `hrdata` is zero.
- R11: A write data phase followed directly by a read address phase to the same doubleword returns the newly written data in the read's data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| hresetn | input | 1 | Active-low synchronous reset |
| haddr | input | ADDR_W | Byte address of the transfer |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Byte count minus one |
| hwdata | input | 64 | Write data, lane k on bits [8k+7:8k] |
| hready | input | 1 | Bus-wide ready; address phase sampled when high |
| hrdata | output | 64 | Read data, unused lanes zero |
| hreadyout | output | 1 | Slave ready, always 1 |
| hresp | output | 1 | Response, always 0 (OKAY) |

## Verification
The bench builds the block with DEPTH set to 4 doublewords and a 32-bit address. Both doublewords the stimulus uses then sit inside the address bits it drives. With four words, every lane offset and every supported size can be reached, and so can each boundary-crossing combination. A stimulus table of sixteen rows covers partial writes followed by full read-backs over two doublewords, with 3-byte transfers placed at the top of a word. Directed tests cover reset, IDLE and BUSY with write attempts, a stalled `hready`, unsupported sizes and a back-to-back write-then-read.

// File: rtl/ahb_lane_pkg.sv
package ahb_lane_pkg;

    localparam int LANES = 8;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        PH_NONE,
        PH_WRITE,
        PH_READ,
        PH_DROP
    } phase_e;

endpackage

// File: rtl/lane_decode.sv
module lane_decode #(
    parameter int LANES = 8,
    parameter int OFS_W = $clog2(LANES)
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [2:0]       sz,
    output logic             valid,
    output logic [LANES-1:0] mask
);
    localparam int CNT_W = OFS_W + 2;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] last_excl;
    logic             sz_ok;

    always_comb begin
        count     = CNT_W'(sz) + CNT_W'(1);
        last_excl = CNT_W'(ofs) + count;
        sz_ok     = (sz == 3'd0) || (sz == 3'd1) || (sz == 3'd2) ||
                    (sz == 3'd3) || (sz == 3'd7);
        valid     = sz_ok && (last_excl <= CNT_W'(LANES));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = valid && (CNT_W'(i) >= CNT_W'(ofs)) && (CNT_W'(i) < last_excl);
    end

    // R6: an accepted transfer covers exactly size+1 lanes
    always_comb begin
        if (valid) begin
            a_r6_lane_count: assert ($countones(mask) == int'(sz) + 1)
                else $error("lane count does not match size");
        end
    end

endmodule

// File: rtl/lane_ram.sv
module lane_ram #(
    parameter int DEPTH = 16,
    parameter int LANES = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [IDX_W-1:0]     idx,
    input  logic [LANES-1:0]     wmask,
    input  logic [8*LANES-1:0]   wdata,
    output logic [8*LANES-1:0]   rdata
);
    logic [7:0] store [DEPTH][LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && wmask[l]) begin
                store[idx][l] <= wdata[8*l +: 8];
            end
        end
        assign rdata[8*l +: 8] = store[idx][l];
    end

endmodule

// File: rtl/ahb_lane_mem.sv
module ahb_lane_mem
    import ahb_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              hresetn,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [63:0]       hwdata,
    input  logic              hready,
    output logic [63:0]       hrdata,
    output logic              hreadyout,
    output logic              hresp
);
    localparam int OFS_W  = $clog2(LANES);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int DATA_W = 8 * LANES;

    phase_e           state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [LANES-1:0] mask_q;
    logic             dec_valid;
    logic [LANES-1:0] dec_mask;
    logic             req;
    logic             ram_we;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] lane_bits;

    assign req = hready && htrans[1];

    lane_decode #(.LANES(LANES), .OFS_W(OFS_W)) u_dec (
        .ofs   (haddr[OFS_W-1:0]),
        .sz    (hsize),
        .valid (dec_valid),
        .mask  (dec_mask)
    );

    assign ram_we = (state_q == PH_WRITE) && hready;

    lane_ram #(.DEPTH(DEPTH), .LANES(LANES), .IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (idx_q),
        .wmask (mask_q),
        .wdata (hwdata),
        .rdata (ram_rdata)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_bits
        assign lane_bits[8*l +: 8] = {8{mask_q[l]}};
    end

    // next data-phase state
    always_comb begin
        state_d = state_q;
        if (hready) begin
            if (!htrans[1]) begin
                state_d = PH_NONE;
            end else if (!dec_valid) begin
                state_d = PH_DROP;
            end else if (hwrite) begin
                state_d = PH_WRITE;
            end else begin
                state_d = PH_READ;
            end
        end
    end

    // state register and captured address phase
    always_ff @(posedge clk) begin
        if (!hresetn) begin
            state_q <= PH_NONE;
            idx_q   <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req) begin
                idx_q  <= haddr[OFS_W +: IDX_W];
                mask_q <= dec_mask;
            end
        end
    end

    // outputs
    always_comb begin
        hreadyout = 1'b1;
        hresp     = 1'b0;
        hrdata    = '0;
        unique case (state_q)
            PH_READ:  hrdata = ram_rdata & lane_bits;
            PH_WRITE,
            PH_DROP,
            PH_NONE:  hrdata = '0;
            default:  hrdata = '0;
        endcase
    end

    a_r1_always_okay: assert property (@(posedge clk) disable iff (!hresetn)
        hreadyout && !hresp);

    a_r2_idle_no_data: assert property (@(posedge clk) disable iff (!hresetn)
        (hready && !htrans[1]) |=> (hrdata == '0 && !ram_we));

    a_r4_stall_hold: assert property (@(posedge clk) disable iff (!hresetn)
        !hready |=> $stable(state_q));

    a_r7_drop_no_data: assert property (@(posedge clk) disable iff (!hresetn)
        (req && !dec_valid) |=> (hrdata == '0 && !ram_we));

endmodule

// File: tb/ahb_lane_mem_tb.sv
module ahb_lane_mem_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int DEPTH      = 4;

    logic              clk = 1'b0;
    logic              hresetn;
    logic [ADDR_W-1:0] haddr;
    logic [1:0]        htrans;
    logic              hwrite;
    logic [2:0]        hsize;
    logic [63:0]       hwdata;
    logic              hready;
    logic [63:0]       hrdata;
    logic              hreadyout;
    logic              hresp;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ahb_lane_mem #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .hresetn(hresetn), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
        .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp)
    );

    typedef struct packed {
        logic [1:0]  tr;
        logic        wr;
        logic [5:0]  addr;
        logic [2:0]  sz;
        logic [63:0] data;   // write data, or expected read data
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'b10, 1'b1, 6'h00, 3'd7, 64'h0011223344556677},
        '{2'b10, 1'b0, 6'h00, 3'd7, 64'h0011223344556677},
        '{2'b10, 1'b1, 6'h01, 3'd0, 64'hDEDEDEDEDEDEAADE},
        '{2'b11, 1'b0, 6'h00, 3'd7, 64'h001122334455AA77},
        '{2'b10, 1'b0, 6'h02, 3'd2, 64'h0000003344550000},
        '{2'b10, 1'b1, 6'h08, 3'd7, 64'h8877665544332211},
        '{2'b11, 1'b1, 6'h0D, 3'd2, 64'hC3C2C1EEEEEEEEEE},
        '{2'b10, 1'b0, 6'h08, 3'd7, 64'hC3C2C15544332211},
        '{2'b10, 1'b0, 6'h0C, 3'd3, 64'hC3C2C15500000000},
        '{2'b10, 1'b1, 6'h0A, 3'd1, 64'h12345678BEEF9ABC},
        '{2'b11, 1'b0, 6'h08, 3'd7, 64'hC3C2C155BEEF2211},
        '{2'b10, 1'b0, 6'h09, 3'd1, 64'h0000000000EF2200},
        '{2'b10, 1'b1, 6'h0E, 3'd1, 64'h5AA5FFFFFFFFFFFF},
        '{2'b10, 1'b0, 6'h08, 3'd7, 64'h5AA5C155BEEF2211},
        '{2'b10, 1'b0, 6'h00, 3'd0, 64'h0000000000000077},
        '{2'b10, 1'b0, 6'h07, 3'd0, 64'h0000000000000000}
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one transfer: address phase, then data phase; returns hrdata of the data phase
    task automatic xfer(input logic [1:0] tr, input logic wr, input logic [5:0] a,
                        input logic [2:0] sz, input logic [63:0] wd,
                        output logic [63:0] rd);
        @(negedge clk);
        htrans = tr; hwrite = wr; haddr = {{(ADDR_W-6){1'b0}}, a}; hsize = sz; hready = 1'b1;
        @(negedge clk);
        htrans = 2'b00; hwrite = 1'b0; hwdata = wd;
        #1 rd = hrdata;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        hresetn = 1'b0; haddr = '0; htrans = 2'b00; hwrite = 1'b0;
        hsize = 3'd0; hwdata = '0; hready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check("R10 hrdata after reset", hrdata, 64'h0);
        check("R1 hreadyout", {63'h0, hreadyout}, 64'h1);
        check("R1 hresp", {63'h0, hresp}, 64'h0);
        hresetn = 1'b1;

        // R3 R5 R6 R8 R9: table walk
        for (int i = 0; i < NV; i++) begin
            xfer(VECS[i].tr, VECS[i].wr, VECS[i].addr, VECS[i].sz,
                 VECS[i].wr ? VECS[i].data : 64'hFFFF_FFFF_FFFF_FFFF, rd);
            if (VECS[i].wr) check("R3 write data phase hrdata zero", rd, 64'h0);
            else            check("R5 R8 R9 read lanes", rd, VECS[i].data);
            check("R1 okay each beat", {62'h0, hreadyout, hresp}, 64'h2);
        end

        // R7: crossing write is a no-op, crossing read returns zero
        xfer(2'b10, 1'b1, 6'h07, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, rd);
        xfer(2'b10, 1'b0, 6'h00, 3'd7, 64'h0, rd);
        check("R7 crossing write ignored", rd, 64'h001122334455AA77);
        xfer(2'b10, 1'b0, 6'h06, 3'd2, 64'h0, rd);
        check("R7 crossing read zero", rd, 64'h0);
        // R7: unsupported size codes
        xfer(2'b10, 1'b1, 6'h00, 3'd5, 64'h0, rd);
        xfer(2'b10, 1'b0, 6'h00, 3'd7, 64'h0, rd);
        check("R7 size 5 write ignored", rd, 64'h001122334455AA77);
        xfer(2'b10, 1'b0, 6'h00, 3'd4, 64'h0, rd);
        check("R7 size 4 read zero", rd, 64'h0);

        // R2: IDLE and BUSY with write attempts
        xfer(2'b00, 1'b1, 6'h00, 3'd7, 64'h0, rd);
        check("R2 idle data phase zero", rd, 64'h0);
        xfer(2'b01, 1'b1, 6'h00, 3'd7, 64'h0, rd);
        check("R2 busy data phase zero", rd, 64'h0);
        xfer(2'b10, 1'b0, 6'h00, 3'd7, 64'h0, rd);
        check("R2 idle/busy write ignored", rd, 64'h001122334455AA77);

        // R4: transfer presented with hready low is not sampled
        @(negedge clk);
        htrans = 2'b10; hwrite = 1'b1; haddr = '0; hsize = 3'd7; hready = 1'b0;
        @(negedge clk);
        htrans = 2'b00; hwrite = 1'b0; hready = 1'b1; hwdata = 64'h0;
        #1 check("R4 stall gives no data", hrdata, 64'h0);
        @(negedge clk);
        xfer(2'b10, 1'b0, 6'h00, 3'd7, 64'h0, rd);
        check("R4 stalled write ignored", rd, 64'h001122334455AA77);

        // R11: write data phase overlapped with read address phase
        @(negedge clk);
        htrans = 2'b10; hwrite = 1'b1; haddr = 32'h8; hsize = 3'd7;
        @(negedge clk);
        hwdata = 64'h0102030405060708;
        htrans = 2'b11; hwrite = 1'b0; haddr = 32'h8; hsize = 3'd7;
        @(negedge clk);
        htrans = 2'b00; hwdata = 64'h0;
        #1 check("R11 read after write", hrdata, 64'h0102030405060708);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule